// File: doc/BRIEF.md
# Serial Majority-Logic Cyclic Decoder

This block corrects a codeword of a binary cyclic block code, such as a difference-set cyclic code, after it is read from memory. A start pulse loads the whole received word in parallel into a circular register. Each cycle, a fixed XOR network forms a set of parity check sums. Every sum includes the bit in the register's low stage, and all other positions are split between the sums with no overlap. A majority gate votes on the sums. The low-stage bit is XORed with the vote and written into the top stage as the register turns by one position. After one full turn every bit has been decoded in place, and the word is back in its original alignment.

Reads without errors are common, so the block keeps watch over the first few turns. When no check sum fires during that window, the block returns the received word at once and skips the rest of the turn. Any word that holds an error goes through the full turn and is corrected.

The code is set by parameters: the word length, the number of check sums, one tap mask per sum, and the length of the early window. The default is the (21,11) code built on the difference set {0,2,7,8,11} mod 21. It uses five check sums and corrects up to two bit errors. A 6-stage build with three check sums is also supported. In that build the vote is the carry function of a full adder.

Top module: `mlg_cyclic_decoder`

## Requirements
- R1: After reset, valid_o, err_o and word_o are all 0. valid_o stays 0 until a start pulse is accepted.
- R2: A word in which every check sum is 0 through the first EARLY turns is returned unchanged. valid_o goes high on the EARLY-th rising edge after the edge that sampled start_i, with err_o = 0.
- R3: For a word with up to two flipped bits in the default code, valid_o goes high on the N-th rising edge after the edge that sampled start_i. word_o then equals the transmitted codeword, so a word that needs correction never takes the short path.
- R4: At the end of a full turn, err_o = 1 when at least one bit was inverted during that turn.
- R5: The bit under decoding is inverted only when more than half of the J check sums are 1. On a tie or a minority the bit passes through unchanged.
- R6: A start pulse that arrives while a word is being decoded has no effect. The word in progress finishes with its normal timing and result, and no extra valid_o pulse follows.
- R7: valid_o is high for exactly one cycle per accepted start. The block is ready for a new start in the cycle in which valid_o is high.
- R8: With N = 6, J = 3 and the check sums {0,1}, {0,2} and {0,3} (bit positions of word_i), the block corrects any single flipped bit of the all-zero and all-one words. It decides using the three-input carry vote.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load word_i and begin decoding; taken only when idle |
| word_i | input | N | Received word, bit i is code position i |
| valid_o | output | 1 | One-cycle pulse: word_o and err_o hold a new result |
| word_o | output | N | Decoded word, held until the next result |
| err_o | output | 1 | Set when the last result needed a correction |

## Verification
The bench builds two instances. The first uses the default 21-bit code with five check sums and a three-turn early window. It receives codewords with no, one and two flipped bits, including adjacent flips, flips at both ends of the word and a flip in the low stage. This exercises both latencies and the counting vote, and shows that no two-error pattern can slip through the short window. The second instance uses the 6-stage build with three check sums. It brings the full-adder carry form of the vote within reach, along with every single-bit position of its repetition words.

// File: rtl/mlg_pkg.sv
package mlg_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Five check sums orthogonal on code position 0 for the (21,11)
    // difference-set code built on {0,2,7,8,11} mod 21.
    localparam logic [4:0][20:0] DSC21_TAPS = {
        21'h061401,   // positions 0,10,12,17,18
        21'h10A009,   // positions 0,3,13,15,20
        21'h014013,   // positions 0,1,4,14,16
        21'h080261,   // positions 0,5,6,9,19
        21'h000985    // positions 0,2,7,8,11
    };

endpackage

// File: rtl/mlg_checksums.sv
module mlg_checksums #(
    parameter int N = 21,
    parameter int J = 5,
    parameter logic [J-1:0][N-1:0] TAPS = mlg_pkg::DSC21_TAPS
) (
    input  logic [N-1:0] word_i,
    output logic [J-1:0] sums_o
);

    // One XOR tree per check sum, taps selected by its mask.
    for (genvar j = 0; j < J; j++) begin : g_sum
        assign sums_o[j] = ^(word_i & TAPS[j]);
    end

endmodule

// File: rtl/mlg_vote.sv
module mlg_vote #(
    parameter int J = 5
) (
    input  logic [J-1:0] sums_i,
    output logic         flip_o
);

    localparam int HALF = J / 2;
    localparam int SW   = $clog2(J + 1);

    if (J == 3) begin : g_carry
        // Three-input majority written as a full-adder carry.
        assign flip_o = (sums_i[0] & sums_i[1]) | (sums_i[2] & (sums_i[0] ^ sums_i[1]));
    end else begin : g_count
        logic [SW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int k = 0; k < J; k++) begin
                ones = ones + SW'(sums_i[k]);
            end
        end
        assign flip_o = (ones > SW'(HALF));
    end

endmodule

// File: rtl/mlg_cyclic_decoder.sv
module mlg_cyclic_decoder #(
    parameter int N     = 21,
    parameter int J     = 5,
    parameter int EARLY = 3,
    parameter logic [J-1:0][N-1:0] TAPS = mlg_pkg::DSC21_TAPS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [N-1:0] word_i,
    output logic         valid_o,
    output logic [N-1:0] word_o,
    output logic         err_o
);

    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        mlg_pkg::phase_e ph;
        logic [N-1:0]    sr;
        logic [CW-1:0]   cnt;
        logic            seen;
        logic            fixed;
        logic            vld;
        logic [N-1:0]    dout;
        logic            err;
    } state_t;

    state_t s_d, s_q;

    logic [J-1:0] sums;
    logic         flip;
    logic         fb;
    logic         any_sum;
    logic [N-1:0] rot;
    logic [N-1:0] unrot;
    logic         early_exit;
    logic         full_exit;

    mlg_checksums #(.N(N), .J(J), .TAPS(TAPS)) u_sums (
        .word_i (s_q.sr),
        .sums_o (sums)
    );

    mlg_vote #(.J(J)) u_vote (
        .sums_i (sums),
        .flip_o (flip)
    );

    // Corrected low-stage bit re-enters at the top stage.
    assign fb      = s_q.sr[0] ^ flip;
    assign rot     = {fb, s_q.sr[N-1:1]};
    assign any_sum = |sums;

    // After EARLY turns the word sits EARLY places down; undo by wiring.
    for (genvar i = 0; i < N; i++) begin : g_unrot
        assign unrot[i] = rot[(i + N - EARLY) % N];
    end

    always_comb begin
        s_d        = s_q;
        s_d.vld    = 1'b0;
        early_exit = 1'b0;
        full_exit  = 1'b0;
        case (s_q.ph)
            mlg_pkg::PH_IDLE: begin
                if (start_i) begin
                    s_d.ph    = mlg_pkg::PH_RUN;
                    s_d.sr    = word_i;
                    s_d.cnt   = '0;
                    s_d.seen  = 1'b0;
                    s_d.fixed = 1'b0;
                end
            end
            mlg_pkg::PH_RUN: begin
                s_d.sr    = rot;
                s_d.cnt   = s_q.cnt + 1'b1;
                s_d.seen  = s_q.seen | any_sum;
                s_d.fixed = s_q.fixed | flip;
                if (s_q.cnt == CW'(EARLY - 1) && !(s_q.seen || any_sum)) begin
                    early_exit = 1'b1;
                    s_d.ph     = mlg_pkg::PH_IDLE;
                    s_d.vld    = 1'b1;
                    s_d.dout   = unrot;
                    s_d.err    = 1'b0;
                end else if (s_q.cnt == CW'(N - 1)) begin
                    full_exit = 1'b1;
                    s_d.ph    = mlg_pkg::PH_IDLE;
                    s_d.vld   = 1'b1;
                    s_d.dout  = rot;
                    s_d.err   = s_q.fixed | flip;
                end
            end
            default: s_d.ph = mlg_pkg::PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o = s_q.vld;
    assign word_o  = s_q.dout;
    assign err_o   = s_q.err;

    // R5: a tie or minority of check sums never inverts the bit.
    p_no_flip_minority_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ph == mlg_pkg::PH_RUN && $countones(sums) * 2 <= J) |-> !flip);

    // R2: the short exit is only taken when no bit has been inverted.
    p_early_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        early_exit |-> (!s_q.fixed && !flip));

    // R3: a result flagged as corrected comes from a full turn.
    p_full_turn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && err_o) |-> ($past(s_q.cnt) == CW'(N - 1)));

    // R6: a start during a turn leaves the turn counting on.
    p_busy_ignore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ph == mlg_pkg::PH_RUN && start_i && !early_exit && !full_exit)
        |=> (s_q.ph == mlg_pkg::PH_RUN && s_q.cnt == CW'($past(s_q.cnt) + 1'b1)));

    // R7: valid is a single-cycle pulse.
    p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R7: leaving a turn always produces a result.
    p_exit_gives_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.ph == mlg_pkg::PH_RUN) |=> (s_q.ph == mlg_pkg::PH_RUN || valid_o));

endmodule

// File: tb/mlg_cyclic_decoder_bench.sv
module mlg_cyclic_decoder_bench;

    localparam int BN = 21;
    localparam int SN = 6;
    localparam int EW = 3;

    typedef struct packed {
        logic [10:0] msg;
        logic [4:0]  e1;
        logic [4:0]  e2;
        logic [1:0]  nerr;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{11'h000, 5'd0,  5'd0,  2'd0},
        '{11'h7FF, 5'd0,  5'd0,  2'd0},
        '{11'h2A5, 5'd0,  5'd0,  2'd0},
        '{11'h135, 5'd0,  5'd0,  2'd1},
        '{11'h4C3, 5'd20, 5'd0,  2'd1},
        '{11'h6E1, 5'd10, 5'd0,  2'd1},
        '{11'h0F0, 5'd0,  5'd20, 2'd2},
        '{11'h555, 5'd3,  5'd4,  2'd2},
        '{11'h1B9, 5'd7,  5'd18, 2'd2},
        '{11'h3C7, 5'd11, 5'd12, 2'd2},
        '{11'h7A2, 5'd5,  5'd0,  2'd1},
        '{11'h008, 5'd2,  5'd19, 2'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          b_start = 1'b0;
    logic [BN-1:0] b_din = '0;
    logic          b_valid;
    logic [BN-1:0] b_dout;
    logic          b_err;

    logic          s_start = 1'b0;
    logic [SN-1:0] s_din = '0;
    logic          s_valid;
    logic [SN-1:0] s_dout;
    logic          s_err;

    int checks = 0;
    int errors = 0;

    mlg_cyclic_decoder u_mlg_cyclic_decoder (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (b_start),
        .word_i  (b_din),
        .valid_o (b_valid),
        .word_o  (b_dout),
        .err_o   (b_err)
    );

    mlg_cyclic_decoder #(
        .N(SN), .J(3), .EARLY(EW),
        .TAPS({6'b001001, 6'b000101, 6'b000011})
    ) u_mlg_cyclic_decoder_small (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .start_i (s_start),
        .word_i  (s_din),
        .valid_o (s_valid),
        .word_o  (s_dout),
        .err_o   (s_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_cw(input logic [BN-1:0] w);
        int ds [5] = '{0, 2, 7, 8, 11};
        for (int t = 0; t < BN; t++) begin
            logic p = 1'b0;
            for (int k = 0; k < 5; k++) p ^= w[(t + ds[k]) % BN];
            if (p) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [BN-1:0] encode(input logic [10:0] m, input logic [BN-1:0] g);
        logic [BN-1:0] c = '0;
        for (int k = 0; k < 11; k++) if (m[k]) c ^= (g << k);
        return c;
    endfunction

    task automatic run_big(input logic [BN-1:0] w, output logic [BN-1:0] o,
                           output logic e, output int lat);
        @(negedge clk);
        b_start = 1'b1;
        b_din   = w;
        @(negedge clk);
        b_start = 1'b0;
        b_din   = '0;
        lat = 0;
        while (!b_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        o = b_dout;
        e = b_err;
        @(negedge clk);
        check(!b_valid, "R7", "valid width", 32'(b_valid), 32'd0);
    endtask

    task automatic run_small(input logic [SN-1:0] w, output logic [SN-1:0] o,
                             output logic e, output int lat);
        @(negedge clk);
        s_start = 1'b1;
        s_din   = w;
        @(negedge clk);
        s_start = 1'b0;
        lat = 0;
        while (!s_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        o = s_dout;
        e = s_err;
    endtask

    task automatic big_case(input logic [BN-1:0] cw, input logic [BN-1:0] flips, input bit dirty,
                            input logic [BN-1:0] g);
        logic [BN-1:0] o;
        logic e;
        int lat;
        run_big(cw ^ flips, o, e, lat);
        check(o == cw, "R3", "decoded word", 32'(o), 32'(cw));
        check(e == dirty, "R4", "error flag", 32'(e), 32'(dirty));
        check(lat == (dirty ? BN : EW), dirty ? "R3" : "R2", "latency", 32'(lat),
              32'(dirty ? BN : EW));
        check(is_cw(cw) && g != '0, "R3", "reference codeword", 32'(cw), 32'(cw));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog actual=%0h expected=%0h", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [BN-1:0] g;
        logic [BN-1:0] cw;
        logic [BN-1:0] o;
        logic [SN-1:0] so;
        logic e;
        int lat;
        bit seen;

        g = '0;
        for (int v = 1; v < 2048; v++) begin
            if (g == '0 && v[0] && v[10] && is_cw(BN'(v))) g = BN'(v);
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check(b_valid == 1'b0 && b_err == 1'b0, "R1", "valid/err in reset",
              {30'd0, b_valid, b_err}, 32'd0);
        rst_n = 1'b1;
        seen = 1'b0;
        repeat (5) begin
            @(negedge clk);
            if (b_valid) seen = 1'b1;
        end
        check(!seen, "R1", "no valid without start", 32'(seen), 32'd0);
        check(b_dout == '0, "R1", "word after reset", 32'(b_dout), 32'd0);

        // Table of messages and flip patterns (R2, R3, R4)
        foreach (VECS[i]) begin
            logic [BN-1:0] fl;
            fl = '0;
            if (VECS[i].nerr >= 2'd1) fl[VECS[i].e1] = 1'b1;
            if (VECS[i].nerr == 2'd2) fl[VECS[i].e2] = 1'b1;
            big_case(encode(VECS[i].msg, g), fl, VECS[i].nerr != 2'd0, g);
        end

        // Random messages with 0, 1 or 2 flips (R2, R3, R4)
        for (int r = 0; r < 30; r++) begin
            logic [BN-1:0] fl;
            int ne;
            int p1;
            int p2;
            ne = int'($urandom % 3);
            p1 = int'($urandom % BN);
            p2 = (p1 + 1 + int'($urandom % (BN - 1))) % BN;
            fl = '0;
            if (ne >= 1) fl[p1] = 1'b1;
            if (ne == 2) fl[p2] = 1'b1;
            big_case(encode(11'($urandom), g), fl, ne != 0, g);
        end

        // R6: start while busy is ignored
        cw = encode(11'h3A6, g);
        @(negedge clk);
        b_start = 1'b1;
        b_din   = cw ^ (BN'(1) << 4);
        @(negedge clk);
        b_start = 1'b0;
        lat = 0;
        repeat (2) begin
            @(negedge clk);
            lat++;
        end
        b_start = 1'b1;
        b_din   = ~cw;
        @(negedge clk);
        lat++;
        b_start = 1'b0;
        b_din   = '0;
        while (!b_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        check(lat == BN, "R6", "latency with busy start", 32'(lat), 32'(BN));
        check(b_dout == cw, "R6", "word with busy start", 32'(b_dout), 32'(cw));
        seen = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (b_valid) seen = 1'b1;
        end
        check(!seen, "R6", "no extra valid", 32'(seen), 32'd0);

        // R7: back-to-back words after a pulse
        run_big(cw, o, e, lat);
        check(o == cw && lat == EW, "R7", "first of pair", 32'(lat), 32'(EW));
        run_big(cw ^ (BN'(1) << 20), o, e, lat);
        check(o == cw && e, "R7", "second of pair", 32'(o), 32'(cw));

        // R8: small build, repetition words, carry vote
        for (int b = 0; b < 2; b++) begin
            logic [SN-1:0] base;
            base = b ? '1 : '0;
            run_small(base, so, e, lat);
            check(so == base && !e && lat == EW, "R8", "small clean", 32'(lat), 32'(EW));
            for (int k = 0; k < SN; k++) begin
                run_small(base ^ (SN'(1) << k), so, e, lat);
                check(so == base, "R8", "small corrected word", 32'(so), 32'(base));
                check(e && lat == SN, "R8", "small flag/latency", 32'(lat), 32'(SN));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule